// File: doc/BRIEF.md
# External Bus Priority Arbiter

This block decides which of five requesters owns a single external bus. The requesters are an outside device asking to take the bus over (bus hold), a DMA engine, and three CPU paths: operand data access, branch-target instruction fetch and sequential instruction fetch. Each requester raises a bit of `req_i` and owns the bus while its bit of `gnt_o` is high. A bus cycle engine outside this block runs the access and pulses `acc_done_i` when it ends.

Ordinary arbitration is strict fixed priority. Two operand sequences change the rules.

- **Split operand access.** An operand access that the bus width forces into several pieces is flagged with `opr_more_i`. Until its last piece completes, no bus hold and no fetch may cut in. DMA may still cut in.
- **Read-modify-write.** A read flagged with `opr_rmw_i` opens a gap before its write. One pending fetch may use that gap. Hold and DMA must wait until the write has completed.

States:
- `ST_IDLE`: unlocked arbitration.
- `ST_HOLD`: bus handed to the outside device.
- `ST_XFER`: one access in flight.
- `ST_SPLIT_GAP`: between the pieces of a split operand.
- `ST_RMW_GAP`: after the read of a read-modify-write.
- `ST_RMW_WRITE`: a fetch has used the gap, and only the write may follow.

Transitions:
- `ST_IDLE` goes to `ST_HOLD` on a winning hold request.
- Any arbitrating state goes to `ST_XFER` on any other win.
- `ST_HOLD` goes to `ST_IDLE` when the hold request drops.
- `ST_XFER` leaves on `acc_done_i` to the context computed for that access:
  - to `ST_SPLIT_GAP` after a piece flagged "more follow";
  - to `ST_RMW_GAP` after a read-modify-write read started from `ST_IDLE`;
  - back to `ST_SPLIT_GAP` after a DMA access taken in that gap;
  - to `ST_RMW_WRITE` after a fetch taken in `ST_RMW_GAP`;
  - otherwise to `ST_IDLE`.

Top module: `bus_prio_arbiter`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after its release with no request, `gnt_o` is all zero.
- R2: `gnt_o` is at all times one-hot or all zero.
- R3: Bit positions of `req_i`/`gnt_o` are 0 hold, 1 DMA, 2 operand, 3 branch fetch, 4 sequential fetch. With the arbiter unlocked, the lowest-numbered request present at a clock edge is granted, visible from that edge.
- R4: A non-hold grant stays unchanged until `acc_done_i` is sampled high. `gnt_o` is then zero for exactly one cycle before the next grant. `acc_done_i` with no access in flight has no effect.
- R5: After an operand grant taken with `opr_more_i`=1, no hold or fetch grant is issued until an operand access taken with `opr_more_i`=0 has completed. In that gap DMA beats the continuing operand access, and a DMA access returns to the same locked gap.
- R6: After an operand read taken with `opr_rmw_i`=1 and `opr_more_i`=0 from the unlocked state completes, a pending branch fetch (else a sequential fetch) is granted ahead of the write. At most one fetch is granted before the write. Hold and DMA are not granted until the write completes.
- R7: A hold grant needs no `acc_done_i` and stays high while `req_i[0]` is high. It drops at the first edge where `req_i[0]` is low.
- R8: `opr_more_i` and `opr_rmw_i` are taken only at the edge where an operand grant is decided. At any other time they have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 5 | Requests: 0 hold, 1 DMA, 2 operand, 3 branch fetch, 4 sequential fetch |
| opr_more_i | input | 1 | Operand access is a piece with more pieces to follow |
| opr_rmw_i | input | 1 | Operand access is the read of a read-modify-write |
| acc_done_i | input | 1 | Single-cycle pulse: current access has ended |
| gnt_o | output | 5 | One-hot grant, same bit order as `req_i` |

## Verification
Two events can meet in one cycle.

- **Split gap.** The arbitration at the start of a split-access gap can coincide with a DMA request, a hold request and fetch requests. The bench sweeps all 32 request patterns into that gap. Only DMA or the operand may win.
- **Read-modify-write gap.** Fetch requests can compete with the pending write, alongside hold and DMA. The bench sweeps all 32 patterns there. It expects the fetch first, and then the write before any hold or DMA.

Expected grants are the lowest set bit of the pattern after masking it by the rule of that gap.

// File: rtl/busarb_pkg.sv
package busarb_pkg;
    localparam int NSRC      = 5;
    localparam int SRC_IW    = $clog2(NSRC);
    localparam int SRC_HOLD  = 0;
    localparam int SRC_DMA   = 1;
    localparam int SRC_OPND  = 2;
    localparam int SRC_BRF   = 3;
    localparam int SRC_SEQF  = 4;

    typedef enum logic [2:0] {
        ST_IDLE      = 3'd0,
        ST_HOLD      = 3'd1,
        ST_XFER      = 3'd2,
        ST_SPLIT_GAP = 3'd3,
        ST_RMW_GAP   = 3'd4,
        ST_RMW_WRITE = 3'd5
    } arb_state_e;
endpackage

// File: rtl/arb_prio_pick.sv
module arb_prio_pick #(
    parameter int N = 5
) (
    input  logic [N-1:0] cand_i,
    output logic [N-1:0] win_o,
    output logic         any_o
);
    // lower index means higher priority; blocked[i] is set once a
    // higher-priority candidate has been seen
    logic [N:0] blocked;
    assign blocked[0] = 1'b0;

    for (genvar i = 0; i < N; i++) begin : g_chain
        assign win_o[i]     = cand_i[i] & ~blocked[i];
        assign blocked[i+1] = blocked[i] | cand_i[i];
    end

    assign any_o = blocked[N];

    always_comb begin
        assert ($onehot0(win_o)) else $error("AST_PICK_ONEHOT"); // R2
    end
endmodule

// File: rtl/arb_elig_mask.sv
module arb_elig_mask
    import busarb_pkg::*;
(
    input  arb_state_e      state_i,
    input  logic            fetch_pend_i,
    output logic [NSRC-1:0] elig_o
);
    always_comb begin
        elig_o = '0;
        unique case (state_i)
            ST_IDLE: begin
                elig_o = '1;
            end
            ST_SPLIT_GAP: begin
                // split operand locked: only DMA and the next piece
                elig_o[SRC_DMA]  = 1'b1;
                elig_o[SRC_OPND] = 1'b1;
            end
            ST_RMW_GAP: begin
                // a fetch takes the gap ahead of the write
                if (fetch_pend_i) begin
                    elig_o[SRC_BRF]  = 1'b1;
                    elig_o[SRC_SEQF] = 1'b1;
                end else begin
                    elig_o[SRC_OPND] = 1'b1;
                end
            end
            ST_RMW_WRITE: begin
                elig_o[SRC_OPND] = 1'b1;
            end
            ST_HOLD, ST_XFER: begin
                elig_o = '0;
            end
            default: begin
                elig_o = '0;
            end
        endcase
    end
endmodule

// File: rtl/arb_after_done.sv
module arb_after_done
    import busarb_pkg::*;
(
    input  logic [SRC_IW-1:0] src_i,
    input  arb_state_e        ctx_i,
    input  logic              more_i,
    input  logic              rmw_i,
    output arb_state_e        next_o
);
    always_comb begin
        next_o = ST_IDLE;
        unique case (int'(src_i))
            SRC_OPND: begin
                if (more_i) begin
                    next_o = ST_SPLIT_GAP;
                end else if (rmw_i && ctx_i == ST_IDLE) begin
                    next_o = ST_RMW_GAP;
                end else begin
                    next_o = ST_IDLE;
                end
            end
            SRC_DMA: begin
                next_o = (ctx_i == ST_SPLIT_GAP) ? ST_SPLIT_GAP : ST_IDLE;
            end
            SRC_BRF, SRC_SEQF: begin
                next_o = (ctx_i == ST_RMW_GAP) ? ST_RMW_WRITE : ST_IDLE;
            end
            default: begin
                next_o = ST_IDLE;
            end
        endcase
    end
endmodule

// File: rtl/bus_prio_arbiter.sv
module bus_prio_arbiter
    import busarb_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] req_i,
    input  logic            opr_more_i,
    input  logic            opr_rmw_i,
    input  logic            acc_done_i,
    output logic [NSRC-1:0] gnt_o
);
    arb_state_e        state_q, state_d;
    arb_state_e        ctx_q, ctx_d;
    arb_state_e        after_st;
    logic [SRC_IW-1:0] src_q, src_d, win_idx;
    logic              more_q, more_d, rmw_q, rmw_d;
    logic [NSRC-1:0]   elig, cand, win;
    logic              win_any;

    arb_elig_mask u_mask (
        .state_i      (state_q),
        .fetch_pend_i (req_i[SRC_BRF] | req_i[SRC_SEQF]),
        .elig_o       (elig)
    );

    assign cand = req_i & elig;

    arb_prio_pick #(.N(NSRC)) u_pick (
        .cand_i (cand),
        .win_o  (win),
        .any_o  (win_any)
    );

    arb_after_done u_after (
        .src_i  (src_q),
        .ctx_i  (ctx_q),
        .more_i (more_q),
        .rmw_i  (rmw_q),
        .next_o (after_st)
    );

    always_comb begin
        win_idx = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (win[i]) win_idx = SRC_IW'(i);
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        ctx_d   = ctx_q;
        src_d   = src_q;
        more_d  = more_q;
        rmw_d   = rmw_q;
        unique case (state_q)
            ST_IDLE, ST_SPLIT_GAP, ST_RMW_GAP, ST_RMW_WRITE: begin
                if (win_any) begin
                    src_d   = win_idx;
                    ctx_d   = state_q;
                    more_d  = opr_more_i & win[SRC_OPND];
                    rmw_d   = opr_rmw_i & win[SRC_OPND];
                    state_d = win[SRC_HOLD] ? ST_HOLD : ST_XFER;
                end
            end
            ST_HOLD: begin
                if (!req_i[SRC_HOLD]) state_d = ST_IDLE;
            end
            ST_XFER: begin
                if (acc_done_i) state_d = after_st;
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            ctx_q   <= ST_IDLE;
            src_q   <= '0;
            more_q  <= 1'b0;
            rmw_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            ctx_q   <= ctx_d;
            src_q   <= src_d;
            more_q  <= more_d;
            rmw_q   <= rmw_d;
        end
    end

    // outputs
    always_comb begin
        gnt_o = '0;
        if (state_q == ST_XFER || state_q == ST_HOLD) begin
            gnt_o[src_q] = 1'b1;
        end
    end

    AST_GNT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt_o)); // R2
    AST_IDLE_HOLD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && req_i[SRC_HOLD]) |=> gnt_o[SRC_HOLD]); // R3
    AST_GNT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        ((|gnt_o[NSRC-1:1]) && !acc_done_i) |=> $stable(gnt_o)); // R4
    AST_DONE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        ((|gnt_o[NSRC-1:1]) && acc_done_i) |=> (gnt_o == '0)); // R4
    AST_SPLIT_NO_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SPLIT_GAP) |=>
            !gnt_o[SRC_HOLD] && !gnt_o[SRC_BRF] && !gnt_o[SRC_SEQF]); // R5
    AST_RMW_NO_HOLD_DMA: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RMW_GAP || state_q == ST_RMW_WRITE) |=>
            !gnt_o[SRC_HOLD] && !gnt_o[SRC_DMA]); // R6
    AST_HOLD_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_o[SRC_HOLD] && req_i[SRC_HOLD]) |=> gnt_o[SRC_HOLD]); // R7
    AST_HOLD_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_o[SRC_HOLD] && !req_i[SRC_HOLD]) |=> !gnt_o[SRC_HOLD]); // R7
endmodule

// File: tb/sim_bus_prio_arbiter.sv
`timescale 1ns/1ps
module sim_bus_prio_arbiter;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] req = '0;
    logic       more = 1'b0, rmw = 1'b0, done = 1'b0;
    logic [4:0] gnt;
    int         n_chk = 0, n_fail = 0;
    bit         finished = 1'b0;

    always #2.5 clk = ~clk;

    bus_prio_arbiter u0 (
        .clk(clk), .rst_n(rst_n), .req_i(req), .opr_more_i(more),
        .opr_rmw_i(rmw), .acc_done_i(done), .gnt_o(gnt)
    );

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [4:0] exp);
        n_chk++;
        if (gnt !== exp) begin
            n_fail++;
            $display("FAIL %s: gnt=%b expected=%b", tag, gnt, exp);
        end
    endtask

    function automatic logic [4:0] lowbit(input logic [4:0] p);
        for (int i = 0; i < 5; i++) if (p[i]) return 5'(1 << i);
        return 5'b0;
    endfunction

    task automatic finish_op(input string tag);
        req = '0; more = 1'b0; rmw = 1'b0; done = 1'b1;
        tick();
        done = 1'b0;
        chk(tag, 5'b0);
    endtask

    initial begin
        repeat (3) tick();
        chk("R1 in reset", 5'b0);
        rst_n = 1'b1;
        tick();
        chk("R1 after release", 5'b0);

        // R3 / R4 / R7 sweep over all request patterns in the unlocked state
        for (int p = 1; p < 32; p++) begin
            req = 5'(p);
            tick();
            chk("R3 idle priority", lowbit(5'(p)));
            if (p[0]) begin
                tick();
                chk("R7 hold kept", 5'b00001);
                done = 1'b1;
                tick();
                done = 1'b0;
                chk("R7 done ignored in hold", 5'b00001);
                req = '0;
                tick();
                chk("R7 hold drop", 5'b0);
            end else begin
                req = '0;
                tick();
                chk("R4 grant held", lowbit(5'(p)));
                finish_op("R4 gap after done");
            end
        end

        // R4: done with nothing in flight
        done = 1'b1;
        tick();
        done = 1'b0;
        req = 5'b00100;
        tick();
        chk("R4 stray done ignored", 5'b00100);
        req = '0;
        tick();
        chk("R4 held after stray done", 5'b00100);
        finish_op("R4 end");

        // R8: flags outside the grant decision have no effect
        req = 5'b00100;
        tick();
        req = '0; more = 1'b1; rmw = 1'b1;
        tick();
        finish_op("R8 access end");
        req = 5'b11001;
        tick();
        chk("R8 flags ignored, unlocked", 5'b00001);
        req = '0;
        tick();
        chk("R8 release", 5'b0);

        // R5 sweep: every pattern into the split gap
        for (int p = 0; p < 32; p++) begin
            logic [4:0] e;
            req = 5'b00100; more = 1'b1;
            tick();
            chk("R5 first piece", 5'b00100);
            finish_op("R5 piece done");
            req = 5'(p);
            e = p[1] ? 5'b00010 : (p[2] ? 5'b00100 : 5'b00000);
            tick();
            chk("R5 split gap arbitration", e);
            if (e == 5'b00010) begin
                finish_op("R5 dma done");
                req = 5'b10101;
                tick();
                chk("R5 lock kept after dma", 5'b00100);
            end else if (e == 5'b00000) begin
                req = 5'b00100;
                tick();
                chk("R5 resume piece", 5'b00100);
            end
            finish_op("R5 last piece done");
            req = 5'b10001;
            tick();
            chk("R5 lock cleared", 5'b00001);
            req = '0;
            tick();
        end

        // R6 sweep: every pattern into the read-modify-write gap
        for (int p = 0; p < 32; p++) begin
            logic [4:0] e;
            req = 5'b00100; rmw = 1'b1;
            tick();
            chk("R6 read", 5'b00100);
            finish_op("R6 read done");
            req = 5'(p) | 5'b00100;
            e = p[3] ? 5'b01000 : (p[4] ? 5'b10000 : 5'b00100);
            tick();
            chk("R6 gap arbitration", e);
            if (e != 5'b00100) begin
                finish_op("R6 fetch done");
                req = 5'(p) | 5'b00100;
                tick();
                chk("R6 write after one fetch", 5'b00100);
            end
            finish_op("R6 write done");
        end

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: run did not complete");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule